// File: doc/BRIEF.md
# Delayed-Clear Phase-Frequency Detector

This block compares a reference clock with a divided oscillator clock and drives pump-up and pump-down pulses toward an external charge pump. Each input is brought into a fast system clock through a synchronizer, and its rising edges are detected there. A reference edge arms the up output. A divided-clock edge arms the down output.

When both outputs are armed, they are not cleared at once. A programmable count of fast-clock cycles passes first, so both pump paths are fully on together before they switch off. Without that overlap, the detector gain would collapse to zero near zero phase error.

An input edge that arrives while the clear is pending is remembered. It re-arms its output as soon as the clear is taken. The charge pump and the loop filter are outside this block.

Top module: `pfd_delayed_reset`

## Requirements
- R1: While rst_ni is low, up_o and dn_o are 0.
- R2: A 0-to-1 change on ref_i, applied before clock edge k, makes up_o read 1 after edge k+2: two synchronizer stages, then the state flop.
- R3: A 0-to-1 change on fb_i makes dn_o read 1 with the same latency as in R2.
- R4: Once up_o and dn_o are both 1, they stay 1 together for exactly clr_dly_i+1 clock cycles, then both clear on the same edge, unless R5 applies.
- R5: A rising edge on an input whose synchronized edge is detected while both outputs are 1 is held, and that output reads 1 again right after the clear.
- R6: A level held high on an input arms its output only once, for its rising edge. After the clear, both outputs stay 0 while the inputs stay high.
- R7: With clr_dly_i = 0, the overlap of up_o and dn_o lasts a single clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference clock, asynchronous |
| fb_i | input | 1 | Divided oscillator clock, asynchronous |
| clr_dly_i | input | 4 | Extra clock cycles before the clear; hold stable while either output is 1 |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |

## Verification
The hardest state to reach is an edge that lands inside the clear window. That edge must fall, after synchronization, between the moment both outputs rise and the moment the clear is taken.

Directed stimulus drives the input low and then high again right after the overlap begins, with a long delay setting. Random toggling at varied delay settings compares every cycle against a cycle model of the requirements. That random run also catches coincident and near-coincident edges that hit the window by chance.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned DLY_W       = 4;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int unsigned STAGES = pfd_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[LAST];

  assign rise_o = sync_q[LAST] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/pfd_clear_timer.sv
module pfd_clear_timer #(
  parameter int unsigned DLY_W = pfd_pkg::DLY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             both_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             clr_o
);
  logic [DLY_W-1:0] cnt_q;

  assign clr_o = both_i && (cnt_q == dly_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               cnt_q <= '0;
    else if (!both_i || clr_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;

  AST_CNT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both_i |-> cnt_q <= dly_i); // R4
endmodule

// File: rtl/pfd_delayed_reset.sv
module pfd_delayed_reset #(
  parameter int unsigned DLY_W       = pfd_pkg::DLY_W,
  parameter int unsigned SYNC_STAGES = pfd_pkg::SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             fb_i,
  input  logic [DLY_W-1:0] clr_dly_i,
  output logic             up_o,
  output logic             dn_o
);
  logic ref_rise, fb_rise;
  logic up_q, dn_q, pend_up_q, pend_dn_q;
  logic both, clr;

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ref_i), .rise_o(ref_rise));

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_fb (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(fb_i), .rise_o(fb_rise));

  assign both = up_q & dn_q;

  pfd_clear_timer #(.DLY_W(DLY_W)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .both_i(both), .dly_i(clr_dly_i), .clr_o(clr));

  // edges seen during the clear window are held until the clear is taken
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      up_q      <= 1'b0;
      dn_q      <= 1'b0;
      pend_up_q <= 1'b0;
      pend_dn_q <= 1'b0;
    end else if (clr) begin
      up_q      <= pend_up_q | ref_rise;
      dn_q      <= pend_dn_q | fb_rise;
      pend_up_q <= 1'b0;
      pend_dn_q <= 1'b0;
    end else begin
      up_q      <= up_q | ref_rise;
      dn_q      <= dn_q | fb_rise;
      pend_up_q <= pend_up_q | (both & ref_rise);
      pend_dn_q <= pend_dn_q | (both & fb_rise);
    end

  assign up_o = up_q;
  assign dn_o = dn_q;

  AST_REF_SETS_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_rise |=> up_q); // R2
  AST_FB_SETS_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_rise |=> dn_q); // R3
  AST_UP_FALLS_AFTER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(up_q) |-> $past(dn_q)); // R4
  AST_DN_FALLS_AFTER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dn_q) |-> $past(up_q)); // R4
  AST_PEND_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_up_q | pend_dn_q) |-> (up_q & dn_q)); // R5
  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (!up_o && !dn_o)); // R1
endmodule

// File: tb/test_pfd_delayed_reset.sv
module test_pfd_delayed_reset;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_in, fb_in;
  logic [3:0] dly;
  logic       up, dn;

  int n_cmp = 0;
  int n_bad = 0;

  pfd_delayed_reset i_pfd_delayed_reset (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_in), .fb_i(fb_in),
    .clr_dly_i(dly), .up_o(up), .dn_o(dn));

  always #5 clk = ~clk;

  // cycle model of the requirements
  logic m_r1, m_r2, m_r3, m_f1, m_f2, m_f3;
  logic m_up, m_dn, m_pu, m_pd;
  int   m_cnt;

  task automatic model_clear();
    {m_r1, m_r2, m_r3, m_f1, m_f2, m_f3} = '0;
    {m_up, m_dn, m_pu, m_pd} = '0;
    m_cnt = 0;
  endtask

  task automatic model_step(input logic r, input logic f);
    logic rr, rf, bo, cl;
    rr = m_r2 & ~m_r3;
    rf = m_f2 & ~m_f3;
    bo = m_up & m_dn;
    cl = bo && (m_cnt == int'(dly));
    if (cl) begin
      m_up = m_pu | rr; m_dn = m_pd | rf; m_pu = 0; m_pd = 0; m_cnt = 0;
    end else begin
      m_pu = m_pu | (bo & rr); m_pd = m_pd | (bo & rf);
      m_up = m_up | rr; m_dn = m_dn | rf;
      m_cnt = bo ? m_cnt + 1 : 0;
    end
    m_r3 = m_r2; m_r2 = m_r1; m_r1 = r;
    m_f3 = m_f2; m_f2 = m_f1; m_f1 = f;
  endtask

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: up/dn actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: advance model, compare every cycle
  task automatic cycle(input string req);
    @(posedge clk);
    @(negedge clk);
    model_step(ref_in, fb_in);
    check(req, {up, dn}, {m_up, m_dn});
  endtask

  task automatic do_reset(input logic [3:0] d);
    @(negedge clk);
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0; dly = d;
    repeat (3) @(negedge clk);
    check("R1", {up, dn}, 2'b00);
    model_clear();
    rst_n = 1'b1;
  endtask

  int ovl;

  initial begin
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0; dly = 4'd0;
    void'($urandom(32'h1234_5eed));
    model_clear();

    // R2 latency
    do_reset(4'd3);
    ref_in = 1'b1;
    cycle("R2"); check("R2", {up, dn}, 2'b00);
    cycle("R2"); check("R2", {up, dn}, 2'b00);
    cycle("R2"); check("R2", {up, dn}, 2'b10);

    // R3 latency
    do_reset(4'd3);
    fb_in = 1'b1;
    cycle("R3"); cycle("R3"); check("R3", {up, dn}, 2'b00);
    cycle("R3"); check("R3", {up, dn}, 2'b01);

    // R4 / R7 overlap length
    foreach (ovl_set[i]) begin
      do_reset(ovl_set[i]);
      ref_in = 1'b1; fb_in = 1'b1;
      ovl = 0;
      for (int c = 0; c < 40; c++) begin
        cycle("R4");
        if (up && dn) ovl++;
      end
      check(ovl_set[i] == 0 ? "R7" : "R4", {1'b0, ovl == int'(ovl_set[i]) + 1}, 2'b01);
      if (ovl != int'(ovl_set[i]) + 1)
        $display("FAIL R4: overlap actual %0d expected %0d", ovl, int'(ovl_set[i]) + 1);
      // R6: levels still high, nothing re-armed
      check("R6", {up, dn}, 2'b00);
    end

    // R5 edge inside the clear window
    do_reset(4'd6);
    ref_in = 1'b1; fb_in = 1'b1;
    for (int c = 0; c < 10 && !(up && dn); c++) cycle("R5");
    ref_in = 1'b0; cycle("R5");
    ref_in = 1'b1; cycle("R5");
    repeat (12) cycle("R5");
    check("R5", {up, dn}, 2'b10);

    // random toggling against the model
    for (int seg = 0; seg < 8; seg++) begin
      do_reset(4'($urandom_range(0, 15)));
      for (int c = 0; c < 2000; c++) begin
        if ($urandom_range(0, 7) == 0) ref_in = ~ref_in;
        if ($urandom_range(0, 7) == 0) fb_in = ~fb_in;
        cycle("R2,R3,R4,R5");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [3:0] ovl_set [4] = '{4'd0, 4'd1, 4'd7, 4'd15};

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule